// File: doc/BRIEF.md
# Receive Descriptor Ring Walker

This block feeds a receive DMA data mover from a circular ring of descriptor tables in memory. Each table holds a fixed number of 16-byte slots, and all tables are the same size. When software has queued at least one table, the walker fetches that table's entries one at a time and decodes each one. It hands the entry's destination address and byte count to the data mover. It then waits for the mover to finish before it fetches the next entry. When it finishes an entry flagged as the end of the table, it advances a read pointer. That pointer carries a rollover bit, so software can tell a full ring from an empty one.

Software queues tables by advancing `sw_wptr`, using the same index-plus-rollover encoding that the read pointer uses. The walker sits idle whenever the two pointers are equal. Descriptor fetches use a valid/ready request. Once `fetch_valid` is raised it stays high, with `fetch_addr` unchanged, until `fetch_ready` is sampled high. One fetch is outstanding at a time. The single response is taken on `desc_valid` only while `desc_ready` is high. Mover commands follow the same rule: `mv_valid` stays high with stable `mv_addr`/`mv_len` until `mv_ready` is sampled high. The mover then reports completion with a one-cycle `mv_done`. A malformed table halts the walker with `err` set until reset.

Top module: `ring_walker`

## Requirements
- R1: From the 128-bit descriptor, `mv_addr` carries bits 53..0 and `mv_len` carries bits 87..64, both unchanged.
- R2: The entry k of the table at index i is fetched from `cfg_ring_base + (i*(cfg_ent_m1+1) + k)*16`.
- R3: Entries of a table are fetched and commanded in ascending order. The next fetch starts only after `mv_done` for the current entry, so a fetch request and a mover command are never active together.
- R4: Bit 88 marks the last entry of a table. `rd_ptr` changes only in the cycle after the `mv_done` of such an entry, and never after other entries.
- R5: `rd_ptr[6:0]` is the table index and `rd_ptr[7]` is the rollover flag. `cfg_depth_m1` holds the ring depth minus one. The index steps 0..`cfg_depth_m1`, then returns to 0 while the flag toggles. For depth 4 the pointer goes 00h,01h,02h,03h,80h,81h,82h,83h,00h.
- R6: The ring is empty when `rd_ptr == sw_wptr` on all 8 bits, and the walker then raises no fetch. Equal index with a different rollover flag means the ring is full, and the walker processes it.
- R7: A non-final entry whose bits 87..64 are not a multiple of 4096 sets `err`, and no command is issued for it. After that, `err` stays set, no fetch or command is raised and `rd_ptr` holds until reset. A final entry may have any length.
- R8: `ioc_pulse` is high for exactly one cycle, the cycle after `mv_done`, when the finished entry has bit 63 set. Otherwise it stays low.
- R9: A non-final entry in the last slot of a table (slot `cfg_ent_m1`) sets `err` in the same way as R7.
- R10: `fetch_valid` and `mv_valid` stay high with stable payload until their ready input is sampled high.
- R11: After reset `rd_ptr` is 00h, and `fetch_valid`, `mv_valid`, `ioc_pulse` and `err` are low.
- R12: Bits 62..54, bits 90..89 (hardware status) and bits 127..91 do not affect the command or the flow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_ring_base | input | 64 | Byte address of ring slot 0 |
| cfg_depth_m1 | input | 7 | Number of tables minus one |
| cfg_ent_m1 | input | 8 | Entries per table minus one |
| sw_wptr | input | 8 | Software write pointer (index + rollover bit 7) |
| fetch_valid | output | 1 | Descriptor fetch request |
| fetch_ready | input | 1 | Fetch request accepted |
| fetch_addr | output | 64 | Descriptor byte address |
| desc_valid | input | 1 | Descriptor data returned |
| desc_ready | output | 1 | Walker waiting for descriptor data |
| desc_data | input | 128 | Descriptor contents |
| mv_valid | output | 1 | Mover command valid |
| mv_ready | input | 1 | Mover command accepted |
| mv_addr | output | 54 | Destination address of the entry |
| mv_len | output | 24 | Byte count of the entry |
| mv_done | input | 1 | Mover finished the current entry |
| rd_ptr | output | 8 | Ring read pointer (index + rollover bit 7) |
| ioc_pulse | output | 1 | Completion interrupt pulse |
| err | output | 1 | Malformed table detected, walker halted |

## Verification
Several properties are checked on every cycle:
- the payload stays stable while a request waits for ready;
- fetch and command exclusivity;
- the pointer moves only after a mover completion and its index stays within the ring depth;
- `err` is sticky and silences both requests;
- `ioc_pulse` only follows `mv_done`.

Other behaviours need the bench's memory model. These are:
- the fetch address arithmetic;
- field extraction;
- the exact rollover sequence over two laps;
- a full ring with equal indices;
- the two error halts with their command counts;
- interrupt selection per entry.

// File: rtl/ring_walker_pkg.sv
package ring_walker_pkg;
  localparam int DESC_W   = 128;
  localparam int DADDR_W  = 54;
  localparam int DLEN_W   = 24;
  localparam int DADDR_LO = 0;
  localparam int IOC_BIT  = 63;
  localparam int DLEN_LO  = 64;
  localparam int EOT_BIT  = 88;
  localparam int PAGE_SH  = 12;
  localparam int SLOT_SH  = 4;

  typedef struct packed {
    logic [DADDR_W-1:0] addr;
    logic               ioc;
    logic [DLEN_W-1:0]  len;
    logic               eot;
  } rw_entry_t;

  typedef enum logic [2:0] {
    ST_IDLE, ST_FETCH, ST_WAIT, ST_CMD, ST_BUSY, ST_HALT
  } rw_state_e;
endpackage

// File: rtl/rw_desc_dec.sv
module rw_desc_dec
  import ring_walker_pkg::*;
(
  input  logic [DESC_W-1:0] raw,
  output rw_entry_t         ent,
  output logic              len_aligned
);
  always_comb begin
    ent.addr    = raw[DADDR_LO +: DADDR_W];
    ent.ioc     = raw[IOC_BIT];
    ent.len     = raw[DLEN_LO +: DLEN_W];
    ent.eot     = raw[EOT_BIT];
    len_aligned = (ent.len[PAGE_SH-1:0] == '0);
  end
endmodule

// File: rtl/rw_addr_gen.sv
module rw_addr_gen #(
  parameter int AW    = 64,
  parameter int IDX_W = 7,
  parameter int ENT_W = 8
) (
  input  logic [AW-1:0]    base,
  input  logic [IDX_W-1:0] tbl_idx,
  input  logic [ENT_W-1:0] ent_m1,
  input  logic [ENT_W-1:0] ent_idx,
  output logic [AW-1:0]    addr
);
  localparam int SW = IDX_W + ENT_W + 2;
  logic [SW-1:0] slot;
  always_comb begin
    slot = SW'(tbl_idx) * (SW'(ent_m1) + SW'(1)) + SW'(ent_idx);
    addr = base + (AW'(slot) << ring_walker_pkg::SLOT_SH);
  end
endmodule

// File: rtl/rw_ring_ptr.sv
module rw_ring_ptr #(
  parameter int IDX_W = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic [IDX_W-1:0] depth_m1,
  output logic [IDX_W:0]   ptr
);
  logic [IDX_W-1:0] idx;
  logic             lap;
  assign idx = ptr[IDX_W-1:0];
  assign lap = ptr[IDX_W];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr <= '0;
    else if (step) begin
      if (idx == depth_m1) ptr <= {~lap, {IDX_W{1'b0}}};
      else                 ptr <= {lap, idx + 1'b1};
    end
  end
endmodule

// File: rtl/ring_walker.sv
module ring_walker
  import ring_walker_pkg::*;
#(
  parameter int AW    = 64,
  parameter int IDX_W = 7,
  parameter int ENT_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [AW-1:0]      cfg_ring_base,
  input  logic [IDX_W-1:0]   cfg_depth_m1,
  input  logic [ENT_W-1:0]   cfg_ent_m1,
  input  logic [IDX_W:0]     sw_wptr,
  output logic               fetch_valid,
  input  logic               fetch_ready,
  output logic [AW-1:0]      fetch_addr,
  input  logic               desc_valid,
  output logic               desc_ready,
  input  logic [DESC_W-1:0]  desc_data,
  output logic               mv_valid,
  input  logic               mv_ready,
  output logic [DADDR_W-1:0] mv_addr,
  output logic [DLEN_W-1:0]  mv_len,
  input  logic               mv_done,
  output logic [IDX_W:0]     rd_ptr,
  output logic               ioc_pulse,
  output logic               err
);
  rw_state_e        state;
  logic [ENT_W-1:0] ent_idx;
  rw_entry_t        dec, cur;
  logic             dec_aligned;
  logic             ring_empty;
  logic             tbl_step;
  logic             bad_entry;

  rw_desc_dec u_dec (
    .raw         (desc_data),
    .ent         (dec),
    .len_aligned (dec_aligned)
  );

  rw_addr_gen #(.AW(AW), .IDX_W(IDX_W), .ENT_W(ENT_W)) u_agen (
    .base    (cfg_ring_base),
    .tbl_idx (rd_ptr[IDX_W-1:0]),
    .ent_m1  (cfg_ent_m1),
    .ent_idx (ent_idx),
    .addr    (fetch_addr)
  );

  rw_ring_ptr #(.IDX_W(IDX_W)) u_ptr (
    .clk      (clk),
    .rst_n    (rst_n),
    .step     (tbl_step),
    .depth_m1 (cfg_depth_m1),
    .ptr      (rd_ptr)
  );

  assign ring_empty  = (rd_ptr == sw_wptr);
  assign tbl_step    = (state == ST_BUSY) && mv_done && cur.eot;
  assign bad_entry   = !dec.eot && (!dec_aligned || ent_idx == cfg_ent_m1);
  assign fetch_valid = (state == ST_FETCH);
  assign desc_ready  = (state == ST_WAIT);
  assign mv_valid    = (state == ST_CMD);
  assign mv_addr     = cur.addr;
  assign mv_len      = cur.len;
  assign err         = (state == ST_HALT);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state     <= ST_IDLE;
      ent_idx   <= '0;
      cur       <= '0;
      ioc_pulse <= 1'b0;
    end else begin
      ioc_pulse <= 1'b0;
      unique case (state)
        ST_IDLE:  if (!ring_empty) state <= ST_FETCH;
        ST_FETCH: if (fetch_ready) state <= ST_WAIT;
        ST_WAIT: if (desc_valid) begin
          cur   <= dec;
          state <= bad_entry ? ST_HALT : ST_CMD;
        end
        ST_CMD:   if (mv_ready) state <= ST_BUSY;
        ST_BUSY: if (mv_done) begin
          ioc_pulse <= cur.ioc;
          if (cur.eot) begin
            ent_idx <= '0;
            state   <= ST_IDLE;
          end else begin
            ent_idx <= ent_idx + 1'b1;
            state   <= ST_FETCH;
          end
        end
        default:  state <= ST_HALT;
      endcase
    end
  end
endmodule

// File: rtl/rw_checker.sv
module rw_checker #(
  parameter int AW    = 64,
  parameter int IDX_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fetch_valid,
  input logic             fetch_ready,
  input logic [AW-1:0]    fetch_addr,
  input logic             mv_valid,
  input logic             mv_ready,
  input logic [53:0]      mv_addr,
  input logic [23:0]      mv_len,
  input logic             mv_done,
  input logic [IDX_W:0]   rd_ptr,
  input logic [IDX_W-1:0] cfg_depth_m1,
  input logic             ioc_pulse,
  input logic             err
);
  assert_ptr_in_ring_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_ptr[IDX_W-1:0] <= cfg_depth_m1);

  assert_ptr_after_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_ptr != $past(rd_ptr)) |-> $past(mv_done));

  assert_fetch_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_valid && !fetch_ready) |=> (fetch_valid && $stable(fetch_addr)));

  assert_cmd_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (mv_valid && !mv_ready) |=> (mv_valid && $stable(mv_addr) && $stable(mv_len)));

  assert_fetch_xor_cmd_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fetch_valid && mv_valid));

  assert_err_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  assert_err_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> (!fetch_valid && !mv_valid));

  assert_ioc_follows_done_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ioc_pulse |-> $past(mv_done));
endmodule

bind ring_walker rw_checker #(.AW(AW), .IDX_W(IDX_W)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .fetch_valid  (fetch_valid),
  .fetch_ready  (fetch_ready),
  .fetch_addr   (fetch_addr),
  .mv_valid     (mv_valid),
  .mv_ready     (mv_ready),
  .mv_addr      (mv_addr),
  .mv_len       (mv_len),
  .mv_done      (mv_done),
  .rd_ptr       (rd_ptr),
  .cfg_depth_m1 (cfg_depth_m1),
  .ioc_pulse    (ioc_pulse),
  .err          (err)
);

// File: tb/ring_walker_tb.sv
module ring_walker_tb;
  localparam logic [63:0] BASE = 64'h0000_0040_0000_1000;
  localparam int NVEC = 8;
  // vector: [7] back-pressure, [6:4] entries in table, [3:0] completion-interrupt mask
  localparam logic [7:0] VEC [NVEC] = '{8'h11, 8'hB5, 8'h48, 8'h20,
                                        8'hCF, 8'h10, 8'hA3, 8'h36};
  localparam logic [7:0] PTR_SEQ [NVEC+1] = '{8'h00, 8'h01, 8'h02, 8'h03,
                                             8'h80, 8'h81, 8'h82, 8'h83, 8'h00};

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [63:0] cfg_ring_base = BASE;
  logic [6:0]  cfg_depth_m1 = 7'd3;
  logic [7:0]  cfg_ent_m1 = 8'd3;
  logic [7:0]  sw_wptr = 8'h00;
  logic fetch_valid, fetch_ready = 1'b0;
  logic [63:0] fetch_addr;
  logic desc_valid = 1'b0, desc_ready;
  logic [127:0] desc_data = '0;
  logic mv_valid, mv_ready = 1'b0;
  logic [53:0] mv_addr;
  logic [23:0] mv_len;
  logic mv_done = 1'b0;
  logic [7:0] rd_ptr;
  logic ioc_pulse, err;

  always #2.5 clk = ~clk;

  ring_walker u_dut (.*);

  int n_chk = 0, n_bad = 0;
  int cmd_cnt = 0, ioc_cnt = 0;
  int exp_slot = 0, exp_k = 0;
  int fetch_e = 0;
  bit stall = 0;
  bit finished = 0;
  logic [127:0] mem [16];

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [127:0] mk_desc(input int v, input int k, input bit last, input bit ioc, input logic [23:0] len);
    logic [127:0] d;
    d = '1;                           // reserved and status bits all ones (R12)
    d[53:0]  = 54'h2A_0000_0000_00 | (54'(v) << 20) | (54'(k) << 12);
    d[63]    = ioc;
    d[87:64] = len;
    d[88]    = last;
    return d;
  endfunction

  function automatic logic [7:0] nxt(input logic [7:0] p);
    return (p[6:0] == 7'd3) ? {~p[7], 7'd0} : {p[7], p[6:0] + 7'd1};
  endfunction

  // descriptor fetch responder
  initial forever begin
    @(negedge clk);
    if (rst_n && fetch_valid) begin
      logic [63:0] a;
      a = fetch_addr;
      fetch_e = int'((a - BASE) >> 4);
      chk(fetch_e == exp_slot*4 + exp_k, "R2 fetch slot", 128'(fetch_e), 128'(exp_slot*4 + exp_k));
      if (stall) begin
        repeat (2) @(negedge clk);
        chk(fetch_valid && fetch_addr == a, "R10 fetch held", 128'(fetch_addr), 128'(a));
      end
      fetch_ready = 1'b1;
      @(negedge clk);
      fetch_ready = 1'b0;
      desc_valid  = 1'b1;
      desc_data   = mem[fetch_e & 15];
      @(negedge clk);
      desc_valid  = 1'b0;
    end
  end

  // data mover responder
  initial forever begin
    @(negedge clk);
    if (rst_n && mv_valid) begin
      int e;
      e = fetch_e & 15;
      chk(mv_addr == mem[e][53:0], "R1 R12 mv_addr", 128'(mv_addr), 128'(mem[e][53:0]));
      chk(mv_len == mem[e][87:64], "R1 mv_len", 128'(mv_len), 128'(mem[e][87:64]));
      if (stall) begin
        repeat (2) @(negedge clk);
        chk(mv_valid && mv_addr == mem[e][53:0], "R10 cmd held", 128'(mv_valid), 128'(1));
      end
      mv_ready = 1'b1;
      cmd_cnt++;
      @(negedge clk);
      mv_ready = 1'b0;
      repeat (2) @(negedge clk);
      mv_done = 1'b1;
      if (mem[e][88]) begin exp_slot = (exp_slot + 1) % 4; exp_k = 0; end
      else exp_k++;
      @(negedge clk);
      mv_done = 1'b0;
      chk(ioc_pulse == mem[e][63], "R8 ioc_pulse", 128'(ioc_pulse), 128'(mem[e][63]));
      if (ioc_pulse) ioc_cnt++;
      @(negedge clk);
      chk(ioc_pulse == 1'b0, "R8 single cycle", 128'(ioc_pulse), 128'(0));
    end
  end

  task automatic do_reset();
    rst_n = 1'b0;
    sw_wptr = 8'h00;
    exp_slot = 0; exp_k = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic wait_ptr(input logic [7:0] target, input string req);
    for (int i = 0; i < 400 && rd_ptr != target; i++) @(negedge clk);
    repeat (6) @(negedge clk);
    chk(rd_ptr == target, req, 128'(rd_ptr), 128'(target));
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    do_reset();
    chk(rd_ptr == 8'h00, "R11 rd_ptr", 128'(rd_ptr), 128'(0));
    chk(!fetch_valid && !mv_valid && !ioc_pulse && !err, "R11 outputs idle",
        128'({fetch_valid, mv_valid, ioc_pulse, err}), 128'(0));
    repeat (10) @(negedge clk);
    chk(!fetch_valid, "R6 empty ring no fetch", 128'(fetch_valid), 128'(0));

    // vector walk: one table per vector, two laps of a 4-deep ring
    for (int v = 0; v < NVEC; v++) begin
      int n, slot, c0, i0;
      logic [3:0] m;
      n = int'(VEC[v][6:4]);
      m = VEC[v][3:0];
      stall = VEC[v][7];
      slot = int'(sw_wptr[6:0]);
      for (int k = 0; k < n; k++)
        mem[slot*4 + k] = mk_desc(v, k, k == n-1, m[k],
                                  (k == n-1) ? 24'(100 + v) : 24'(4096 * (k + 1)));
      c0 = cmd_cnt; i0 = ioc_cnt;
      sw_wptr = nxt(sw_wptr);
      wait_ptr(PTR_SEQ[v+1], "R4 R5 rd_ptr after table");
      chk(cmd_cnt - c0 == n, "R3 commands per table", 128'(cmd_cnt - c0), 128'(n));
      chk(ioc_cnt - i0 == $countones(m & 4'((1 << n) - 1)), "R8 ioc count",
          128'(ioc_cnt - i0), 128'($countones(m & 4'((1 << n) - 1))));
      chk(!fetch_valid && !err, "R6 idle when caught up", 128'({fetch_valid, err}), 128'(0));
    end
    stall = 0;

    // full ring: equal index, different rollover flag
    do_reset();
    for (int s = 0; s < 4; s++) mem[s*4] = mk_desc(20 + s, 0, 1'b1, 1'b0, 24'd64);
    begin
      int c0;
      c0 = cmd_cnt;
      sw_wptr = 8'h80;
      wait_ptr(8'h80, "R6 full ring drained");
      chk(cmd_cnt - c0 == 4, "R6 full ring commands", 128'(cmd_cnt - c0), 128'(4));
    end

    // unaligned length on a non-final entry
    do_reset();
    mem[0] = mk_desc(30, 0, 1'b0, 1'b1, 24'd4100);
    begin
      int c0;
      c0 = cmd_cnt;
      sw_wptr = 8'h01;
      repeat (30) @(negedge clk);
      chk(err == 1'b1, "R7 err set", 128'(err), 128'(1));
      chk(cmd_cnt == c0, "R7 no command", 128'(cmd_cnt - c0), 128'(0));
      chk(rd_ptr == 8'h00, "R7 ptr held", 128'(rd_ptr), 128'(0));
    end

    // table overrun: no end mark within the configured entry count
    do_reset();
    for (int k = 0; k < 4; k++) mem[k] = mk_desc(40, k, 1'b0, 1'b0, 24'd8192);
    begin
      int c0;
      c0 = cmd_cnt;
      sw_wptr = 8'h01;
      repeat (100) @(negedge clk);
      chk(err == 1'b1, "R9 err set", 128'(err), 128'(1));
      chk(cmd_cnt - c0 == 3, "R9 commands before halt", 128'(cmd_cnt - c0), 128'(3));
      chk(rd_ptr == 8'h00 && !mv_valid, "R9 ptr held", 128'(rd_ptr), 128'(0));
    end

    do_reset();
    chk(!err && rd_ptr == 8'h00, "R11 reset clears err", 128'({err, rd_ptr}), 128'(0));

    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule